// File: doc/BRIEF.md
# Virtualized Compare Timer Unit

This block watches a free-running 64-bit system counter that arrives on an input port. It compares that counter against software-programmed deadlines on two channels. The physical channel uses the raw counter. The virtual channel first subtracts a 64-bit offset, which privileged software sets, so a guest sees a shifted time base. Each channel has four pieces: an enable and a mask bit, a 64-bit deadline register, a 32-bit signed countdown view of the deadline, and a level interrupt.

All register state is reached through a plain address/data port. Writes take effect on the rising clock edge while `reg_we` is high. Reads are combinational from `reg_addr`. The fire test is a true unsigned comparison of (counter − offset) against the deadline. It is never a sign check on a wrapped difference, so deadlines far apart in the 64-bit range still behave correctly.

Top module: `vtimer_unit`

## Requirements
- R1: After reset, the offset and both deadlines are 0, both channels are disabled and unmasked, and both interrupt outputs are low.
- R2: When the physical channel is enabled, its status bit is 1 exactly when the counter, taken as an unsigned 64-bit value, is greater than or equal to its deadline.
- R3: When the virtual channel is enabled, its status bit is 1 exactly when the local time (counter − offset) is greater than or equal to its deadline. The subtraction wraps modulo 2^64 and the comparison is unsigned.
- R4: Status does not depend on the sign bit of (local time − deadline). For example, counter 0x1000_0000_0000_0002 with deadline 1 gives status 1, and counter 0x8000_0000_0000_0005 with deadline 3 also gives status 1.
- R5: A disabled channel reads status 0 and drives its interrupt low, whatever its deadline and the counter are.
- R6: Reading a channel's countdown view returns the low 32 bits of deadline − local time (wrapping), zero-extended to 64 bits.
- R7: Writing a channel's countdown view with value w sets its deadline to local time + w[31:0] sign-extended to 64 bits. Local time is taken from the counter present during the write cycle.
- R8: Each interrupt output is a register. Its value after an edge is status AND enable AND NOT mask, evaluated on the inputs and state present just before that edge, so a cause shows on the pin one edge later.
- R9: The offset affects only the virtual channel. The physical channel's status and countdown view ignore it.
- R10: Register map (3-bit address): 0 offset; 1 physical deadline; 2 physical countdown; 3 physical control; 4 virtual deadline; 5 virtual countdown; 6 virtual control; 7 reads 0 and ignores writes. The control fields are bit 0 enable and bit 1 mask. Bit 2 is the read-only status, and the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 64 | Free-running system counter value |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Combinational read data for reg_addr |
| irq_phys | output | 1 | Physical channel level interrupt |
| irq_virt | output | 1 | Virtual channel level interrupt |

## Verification
Two events can land in the same cycle: a register write that moves the comparison (an offset change or a countdown write) and a counter step that crosses the deadline. The bench provokes this by writing the offset, and separately the countdown view, in the very cycle the counter jumps across the virtual deadline. A behavioural model computes the interrupt from the pre-edge state and counter, then applies the write. The two must agree on every clock, so a design that applies the write before evaluating the interrupt, or samples the wrong counter for the countdown write, is caught.

// File: rtl/vtimer_pkg.sv
package vtimer_pkg;
    localparam int CNT_W  = 64;
    localparam int TV_W   = 32;
    localparam int ADDR_W = 3;
    localparam int NCH    = 2;
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int REGS_PER_CH = 3;
    localparam int PHYS_CH = 0;
    localparam int VIRT_CH = 1;

    typedef enum logic [2:0] {
        F_NONE = 3'd0,
        F_OFF  = 3'd1,
        F_CVAL = 3'd2,
        F_TVAL = 3'd3,
        F_CTRL = 3'd4
    } reg_field_e;

    typedef struct packed {
        logic [CNT_W-1:0]           off;
        logic [NCH-1:0][CNT_W-1:0]  cval;
        logic [NCH-1:0]             en;
        logic [NCH-1:0]             mask;
        logic [NCH-1:0]             irq;
    } tmr_state_t;
endpackage

// File: rtl/vtimer_regdec.sv
module vtimer_regdec
    import vtimer_pkg::*;
(
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output reg_field_e        field,
    output logic [CH_W-1:0]   ch,
    output logic              wr_off,
    output logic [NCH-1:0]    wr_cval,
    output logic [NCH-1:0]    wr_tval,
    output logic [NCH-1:0]    wr_ctrl
);
    always_comb begin
        field = F_NONE;
        ch    = '0;
        if (addr == '0) begin
            field = F_OFF;
        end
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < REGS_PER_CH; k++) begin
                if (addr == ADDR_W'(1 + REGS_PER_CH * c + k)) begin
                    ch = CH_W'(c);
                    case (k)
                        0:       field = F_CVAL;
                        1:       field = F_TVAL;
                        default: field = F_CTRL;
                    endcase
                end
            end
        end
    end

    assign wr_off = we && (field == F_OFF);

    for (genvar c = 0; c < NCH; c++) begin : g_wr
        assign wr_cval[c] = we && (field == F_CVAL) && (ch == CH_W'(c));
        assign wr_tval[c] = we && (field == F_TVAL) && (ch == CH_W'(c));
        assign wr_ctrl[c] = we && (field == F_CTRL) && (ch == CH_W'(c));
    end
endmodule

// File: rtl/vtimer_chan.sv
module vtimer_chan
    import vtimer_pkg::*;
(
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] off,
    input  logic [CNT_W-1:0] cval,
    input  logic             en,
    input  logic             mask,
    input  logic [TV_W-1:0]  tv_wdata,
    output logic             status,
    output logic             irq_next,
    output logic [TV_W-1:0]  tval_rd,
    output logic [CNT_W-1:0] cval_from_tv
);
    logic [CNT_W-1:0] local_t;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] tv_sext;

    always_comb begin
        local_t      = cnt - off;
        status       = en && (local_t >= cval);
        irq_next     = status && en && !mask;
        remain       = cval - local_t;
        tval_rd      = remain[TV_W-1:0];
        tv_sext      = {{(CNT_W-TV_W){tv_wdata[TV_W-1]}}, tv_wdata};
        cval_from_tv = local_t + tv_sext;
    end
endmodule

// File: rtl/vtimer_unit.sv
module vtimer_unit
    import vtimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq_phys,
    output logic              irq_virt
);
    tmr_state_t st_q, st_d;

    reg_field_e      field;
    logic [CH_W-1:0] rd_ch;
    logic            wr_off;
    logic [NCH-1:0]  wr_cval, wr_tval, wr_ctrl;

    logic [NCH-1:0][CNT_W-1:0] off_eff;
    logic [NCH-1:0][CNT_W-1:0] cval_tv;
    logic [NCH-1:0][TV_W-1:0]  tval_rd;
    logic [NCH-1:0]            stat;
    logic [NCH-1:0]            irq_n;

    vtimer_regdec u_dec (
        .we      (reg_we),
        .addr    (reg_addr),
        .field   (field),
        .ch      (rd_ch),
        .wr_off  (wr_off),
        .wr_cval (wr_cval),
        .wr_tval (wr_tval),
        .wr_ctrl (wr_ctrl)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        if (c == VIRT_CH) begin : g_virt
            assign off_eff[c] = st_q.off;
        end else begin : g_phys
            assign off_eff[c] = '0;
        end

        vtimer_chan u_chan (
            .cnt          (cnt_i),
            .off          (off_eff[c]),
            .cval         (st_q.cval[c]),
            .en           (st_q.en[c]),
            .mask         (st_q.mask[c]),
            .tv_wdata     (reg_wdata[TV_W-1:0]),
            .status       (stat[c]),
            .irq_next     (irq_n[c]),
            .tval_rd      (tval_rd[c]),
            .cval_from_tv (cval_tv[c])
        );

        // R5: a disabled channel never reports status
        assert_dis_no_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !st_q.en[c] |-> !stat[c]);

        // R8: a raised interrupt needs enable set and mask clear in the cycle before
        assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.irq[c] |-> $past(st_q.en[c] && !st_q.mask[c]));

        // R7: countdown write lands as local time plus sign-extended value
        assert_tval_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_tval[c]) |-> st_q.cval[c] == $past(cnt_i - off_eff[c] +
                {{(CNT_W-TV_W){reg_wdata[TV_W-1]}}, reg_wdata[TV_W-1:0]}));
    end

    // R9: an offset write leaves both deadlines untouched
    assert_off_keeps_cval_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_off) |-> $stable(st_q.cval));

    // R10: at most one write target per cycle
    assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_off, wr_cval, wr_tval, wr_ctrl}));

    always_comb begin
        st_d = st_q;
        if (wr_off) begin
            st_d.off = reg_wdata;
        end
        for (int c = 0; c < NCH; c++) begin
            if (wr_cval[c]) begin
                st_d.cval[c] = reg_wdata;
            end else if (wr_tval[c]) begin
                st_d.cval[c] = cval_tv[c];
            end
            if (wr_ctrl[c]) begin
                st_d.en[c]   = reg_wdata[0];
                st_d.mask[c] = reg_wdata[1];
            end
            st_d.irq[c] = irq_n[c];
        end

        case (field)
            F_OFF:   reg_rdata = st_q.off;
            F_CVAL:  reg_rdata = st_q.cval[rd_ch];
            F_TVAL:  reg_rdata = {{(CNT_W-TV_W){1'b0}}, tval_rd[rd_ch]};
            F_CTRL:  reg_rdata = {{(CNT_W-3){1'b0}}, stat[rd_ch],
                                  st_q.mask[rd_ch], st_q.en[rd_ch]};
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_phys = st_q.irq[PHYS_CH];
    assign irq_virt = st_q.irq[VIRT_CH];
endmodule

// File: tb/vtimer_unit_test.sv
module vtimer_unit_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt_i = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq_phys, irq_virt;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // behavioural reference state
    logic [63:0] m_off;
    logic [63:0] m_cval [2];
    bit          m_en [2];
    bit          m_mask [2];
    bit          m_irq [2];

    vtimer_unit uut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_phys(irq_phys), .irq_virt(irq_virt)
    );

    always #(CLK_P/2) clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog: actual=hung expected=finish");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] loc(input int ch, input logic [63:0] c);
        return (ch == 1) ? c - m_off : c;
    endfunction

    function automatic bit mstat(input int ch, input logic [63:0] c);
        if (!m_en[ch]) return 1'b0;
        return loc(ch, c) >= m_cval[ch];
    endfunction

    function automatic logic [63:0] mread(input logic [2:0] a, input logic [63:0] c);
        logic [63:0] d;
        case (a)
            3'd0: return m_off;
            3'd1: return m_cval[0];
            3'd2: begin d = m_cval[0] - loc(0, c); return {32'd0, d[31:0]}; end
            3'd3: return {61'd0, mstat(0, c), m_mask[0], m_en[0]};
            3'd4: return m_cval[1];
            3'd5: begin d = m_cval[1] - loc(1, c); return {32'd0, d[31:0]}; end
            3'd6: return {61'd0, mstat(1, c), m_mask[1], m_en[1]};
            default: return 64'd0;
        endcase
    endfunction

    // one clock: drive at negedge, compare, advance the model to the next negedge
    task automatic step(input logic [63:0] c, input bit w, input logic [2:0] a,
                        input logic [63:0] d, input string tag);
        bit nirq [2];
        int ch;
        cnt_i = c; reg_we = w; reg_addr = a; reg_wdata = d;
        #1;
        check(tag, reg_rdata, mread(a, c));
        check("R8 irq_phys", {63'd0, irq_phys}, {63'd0, m_irq[0]});
        check("R8 irq_virt", {63'd0, irq_virt}, {63'd0, m_irq[1]});
        for (int i = 0; i < 2; i++) nirq[i] = mstat(i, c) && m_en[i] && !m_mask[i];
        if (w) begin
            ch = (a >= 3'd4) ? 1 : 0;
            case (a)
                3'd0: m_off = d;
                3'd1, 3'd4: m_cval[ch] = d;
                3'd2, 3'd5: m_cval[ch] = loc(ch, c) + {{32{d[31]}}, d[31:0]};
                3'd3, 3'd6: begin m_en[ch] = d[0]; m_mask[ch] = d[1]; end
                default: ;
            endcase
        end
        for (int i = 0; i < 2; i++) m_irq[i] = nirq[i];
        @(negedge clk);
    endtask

    task automatic rd(input logic [63:0] c, input logic [2:0] a, input string tag);
        step(c, 1'b0, a, 64'd0, tag);
    endtask

    task automatic wr(input logic [63:0] c, input logic [2:0] a, input logic [63:0] d, input string tag);
        step(c, 1'b1, a, d, tag);
    endtask

    logic [63:0] lf;

    initial begin
        m_off = '0;
        for (int i = 0; i < 2; i++) begin
            m_cval[i] = '0; m_en[i] = 0; m_mask[i] = 0; m_irq[i] = 0;
        end
        @(negedge clk);
        @(negedge clk);
        // R1: reset state, visible while reset is held
        check("R1 irq_phys in reset", {63'd0, irq_phys}, 64'd0);
        check("R1 irq_virt in reset", {63'd0, irq_virt}, 64'd0);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) rd(64'd0, 3'(a), "R1 reset read");

        // R2: physical compare around the deadline
        wr(64'd0, 3'd1, 64'd100, "R10 write phys cval");
        wr(64'd0, 3'd3, 64'd1, "R10 phys enable");
        for (int k = 96; k <= 104; k++) rd(64'(k), 3'd3, "R2 phys status ramp");

        // R6: countdown reads, positive and negative remaining time
        rd(64'd90, 3'd2, "R6 tval read positive");
        rd(64'd110, 3'd2, "R6 tval read negative");

        // R9 and R3: offset moves only the virtual channel
        wr(64'd110, 3'd0, 64'd1000, "R9 write offset");
        rd(64'd110, 3'd3, "R9 phys status ignores offset");
        rd(64'd50, 3'd2, "R9 phys tval ignores offset");
        wr(64'd110, 3'd4, 64'd50, "R10 write virt cval");
        wr(64'd110, 3'd6, 64'd1, "R10 virt enable");
        for (int k = 1046; k <= 1054; k++) rd(64'(k), 3'd6, "R3 virt status ramp");
        rd(64'd1040, 3'd5, "R6 virt tval read");
        // wrapping local time: counter below offset gives a huge local value
        rd(64'd5, 3'd6, "R3 wrapped local time");

        // R4: unsigned compare, no sign test
        wr(64'd0, 3'd0, 64'd0, "R9 clear offset");
        wr(64'd0, 3'd4, 64'd1, "R4 set cval 1");
        rd(64'h1000_0000_0000_0002, 3'd6, "R4 large counter");
        wr(64'd0, 3'd4, 64'd3, "R4 set cval 3");
        rd(64'h8000_0000_0000_0005, 3'd6, "R4 top bit counter");
        rd(64'h8000_0000_0000_0005, 3'd6, "R4 top bit counter hold");
        wr(64'd0, 3'd1, 64'hFFFF_FFFF_FFFF_FFF0, "R4 phys cval near top");
        rd(64'h0000_0000_0000_0010, 3'd3, "R4 small counter below huge cval");
        rd(64'hFFFF_FFFF_FFFF_FFF0, 3'd3, "R4 counter at huge cval");

        // R8: mask suppresses the pin but not the status bit
        wr(64'h8000_0000_0000_0005, 3'd6, 64'd3, "R8 mask virt");
        rd(64'h8000_0000_0000_0005, 3'd6, "R8 masked status");
        rd(64'h8000_0000_0000_0005, 3'd6, "R8 masked pin low");
        wr(64'h8000_0000_0000_0005, 3'd6, 64'd1, "R8 unmask virt");
        rd(64'h8000_0000_0000_0005, 3'd6, "R8 unmasked");

        // R7: countdown writes, negative and positive
        wr(64'd2000, 3'd0, 64'd500, "R9 offset 500");
        wr(64'd2000, 3'd5, 64'h0000_0000_FFFF_FFF0, "R7 tval write -16");
        rd(64'd2001, 3'd4, "R7 cval after negative tval");
        wr(64'd2001, 3'd5, 64'd20, "R7 tval write +20");
        rd(64'd2001, 3'd4, "R7 cval after positive tval");
        rd(64'd2005, 3'd5, "R7 tval after counter moves");
        for (int k = 2018; k <= 2024; k++) rd(64'(k), 3'd6, "R7 fire at new deadline");
        wr(64'd2000, 3'd2, 64'h0000_0000_8000_0000, "R7 phys tval most negative");
        rd(64'd2000, 3'd1, "R7 phys cval after most negative");

        // R5: disabling forces status and pin low
        wr(64'hFFFF_FFFF_FFFF_FFFF, 3'd3, 64'd0, "R5 disable phys");
        rd(64'hFFFF_FFFF_FFFF_FFFF, 3'd3, "R5 disabled status");
        rd(64'hFFFF_FFFF_FFFF_FFFF, 3'd3, "R5 disabled pin");
        wr(64'hFFFF_FFFF_FFFF_FFFF, 3'd6, 64'd2, "R5 disable virt masked");
        rd(64'hFFFF_FFFF_FFFF_FFFF, 3'd6, "R5 virt disabled status");

        // R10: unused address reads 0 and ignores writes
        wr(64'd7, 3'd7, 64'hDEAD_BEEF_0000_0001, "R10 write addr 7");
        for (int a = 0; a < 8; a++) rd(64'd7, 3'(a), "R10 map after addr 7 write");

        // same-cycle: register write while the counter crosses the deadline
        wr(64'd0, 3'd6, 64'd1, "R8 re-enable virt");
        wr(64'd0, 3'd0, 64'd0, "R3 offset 0");
        wr(64'd0, 3'd4, 64'd300, "R3 virt cval 300");
        rd(64'd299, 3'd6, "R3 below deadline");
        wr(64'd301, 3'd0, 64'd10, "R3 offset write as counter crosses");
        rd(64'd301, 3'd6, "R3 after offset write");
        wr(64'd320, 3'd5, 64'd5, "R7 tval write as counter crosses");
        rd(64'd320, 3'd6, "R7 after tval write");
        rd(64'd326, 3'd6, "R7 after new deadline");

        // mixed sweep of counter moves and writes
        lf = 64'h1234_5678_9ABC_DEF1;
        for (int n = 0; n < 400; n++) begin
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            if (lf[7:5] == 3'd0)
                wr({48'd0, lf[23:8]}, lf[2:0], {48'd0, lf[39:24]}, "R10 sweep write");
            else if (lf[7:5] == 3'd1)
                wr({48'd0, lf[23:8]}, (lf[0] ? 3'd3 : 3'd6), {62'd0, lf[9], 1'b1}, "R10 sweep ctrl");
            else
                rd({48'd0, lf[23:8]}, lf[2:0], "R2 R3 sweep read");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule